// File: doc/BRIEF.md
# Two-Channel Interrupt Prioritizer and Vector Generator

This block collects interrupt requests from two serial channels, picks the most urgent one and presents it to a CPU. It drives a single interrupt request line and returns an interrupt vector. Each channel raises four kinds of request: a received character, a special receive condition, an emptied transmit buffer, and an external/status change. Every request is latched into a pending bit that stays set until software clears it. A pending bit is cleared by reading receive data, by writing transmit data, by an error-reset command or by an external-status reset command. The pending bits are always visible on a status port, so software can poll them with every enable off.

Each channel has a small control register. It holds one enable per request kind and a status-affects-vector flag. The flag turns on vector modification when it is set in either channel, and the modification then applies to both channels. The block also holds a base vector. When the CPU acknowledges, the block latches a vector. With modification on, a 3-bit code for the winning request replaces a field of the base vector. With modification off, the base vector is returned as written. The latched vector stays unchanged until the next acknowledge.

Top module: `irq_vec_ctrl`

## Requirements
- R1: An event input sets its pending bit on the next clock edge whatever the enables are. The `pend` bit index is the source code: channel A uses 4..7 and channel B uses 0..3. Within a channel the offsets are 0 transmit empty, 1 external/status, 2 receive character, 3 special receive.
- R2: `irq` is high exactly when a pending source has its enable bit set. The control write fields are bit0 receive-character enable, bit1 special-receive enable, bit2 transmit enable, bit3 external/status enable and bit4 status-affects-vector.
- R3: Priority from highest to lowest: channel A special receive, A receive character, A transmit, A external/status, then the same four kinds for channel B in the same order.
- R4: If the status-affects-vector bit is set in either channel's control register, an acknowledge returns the base vector with bits [3:1] replaced by the winning source code. All other bits are kept.
- R5: If the status-affects-vector bit is clear in both channels, an acknowledge returns the base vector unchanged.
- R6: `vec` is loaded only on the clock edge where `iack` is high and is visible in the following cycle. It then holds through later requests and later base-vector writes until the next acknowledge.
- R7: A transmit-empty event sets its pending bit only if a transmit data write has occurred since that channel's previous transmit-empty event. A transmit data write clears the transmit pending bit.
- R8: A receive data read clears receive-character pending. An error reset clears special-receive pending. An external-status reset clears external/status pending. If a set and a clear of the same bit arrive in the same cycle, the set wins.
- R9: An acknowledge with no enabled pending source returns the base vector unchanged, even with modification on.
- R10: After synchronous reset, `pend`, `irq`, `vec`, the base vector and both control registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_char_set | input | 2 | Received-character event, per channel (bit0 = A, bit1 = B) |
| rx_spec_set | input | 2 | Special receive condition event, per channel |
| tx_empty_set | input | 2 | Transmit buffer became empty, per channel |
| ext_set | input | 2 | External/status change event, per channel |
| rx_rd | input | 2 | Receive data read, clears receive-character pending |
| tx_wr | input | 2 | Transmit data write, arms and clears transmit pending |
| err_rst | input | 2 | Error reset command, clears special-receive pending |
| ext_rst | input | 2 | External-status reset command |
| ctl_we | input | 2 | Control register write strobe, per channel |
| ctl_wdata | input | 5 | Control write data (enables and status-affects-vector flag) |
| base_we | input | 1 | Base vector write strobe |
| base_wdata | input | 8 | Base vector write data |
| iack | input | 1 | Interrupt acknowledge, latches the vector |
| irq | output | 1 | Interrupt request |
| vec | output | 8 | Latched interrupt vector |
| pend | output | 8 | Pending bits, indexed by source code |

## Verification
The bench builds the block with an 8-bit vector and the code field at bit 1. A code of zero then matches the base bits it replaces, and it differs from them in the other cases. The base vector 0x51 has bit 0 set and a nonzero upper nibble. This shows that only bits [3:1] are replaced and that the code merges with the bits around it. Later the base changes to 0xF0, which shows that a base write between acknowledges reaches only the next latched vector.

// File: rtl/ivc_pkg.sv
// Package: shared constants, source encoding and the fixed priority order
// of the interrupt vector controller. Assumes two channels, four sources each.
package ivc_pkg;
    localparam int NCH        = 2;
    localparam int SRC_PER_CH = 4;
    localparam int NSRC       = NCH * SRC_PER_CH;
    localparam int CODE_W     = $clog2(NSRC);

    // Source offset inside a channel's code group
    typedef enum logic [1:0] {
        SRC_TX   = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_RXC  = 2'd2,
        SRC_SPEC = 2'd3
    } src_e;

    // Control register field positions
    localparam int CTL_EN_RXC  = 0;
    localparam int CTL_EN_SPEC = 1;
    localparam int CTL_EN_TX   = 2;
    localparam int CTL_EN_EXT  = 3;
    localparam int CTL_SAV     = 4;
    localparam int CTL_W       = 5;

    // Channel index 0 (A) owns the upper code group
    function automatic int group_of(input int ch);
        return NCH - 1 - ch;
    endfunction

    // Map priority rank (0 = most urgent) to a source code
    function automatic logic [CODE_W-1:0] rank_to_code(input int rank);
        int   ch;
        src_e s;
        ch = rank / SRC_PER_CH;
        case (rank % SRC_PER_CH)
            0:       s = SRC_SPEC;
            1:       s = SRC_RXC;
            2:       s = SRC_TX;
            default: s = SRC_EXT;
        endcase
        return CODE_W'(group_of(ch) * SRC_PER_CH + int'(s));
    endfunction
endpackage

// File: rtl/ivc_src_bank.sv
// Module: pending-bit bank for one channel. Latches the four request kinds
// until software clears them; set wins over a same-cycle clear. The transmit
// source is armed by a data write and fires once per armed empty event.
module ivc_src_bank
    import ivc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_char_set,
    input  logic                  rx_spec_set,
    input  logic                  tx_empty_set,
    input  logic                  ext_set,
    input  logic                  rx_rd,
    input  logic                  tx_wr,
    input  logic                  err_rst,
    input  logic                  ext_rst,
    output logic [SRC_PER_CH-1:0] pend
);
    logic tx_armed;
    logic tx_fire;

    assign tx_fire = tx_empty_set && tx_armed;

    // Track whether a transmit write happened since the last empty event
    always_ff @(posedge clk) begin
        if (!rst_n)            tx_armed <= 1'b0;
        else if (tx_wr)        tx_armed <= 1'b1;
        else if (tx_empty_set) tx_armed <= 1'b0;
    end

    // Pending flags: set by events, cleared by the matching software action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            if (rx_char_set)  pend[SRC_RXC]  <= 1'b1;
            else if (rx_rd)   pend[SRC_RXC]  <= 1'b0;
            if (rx_spec_set)  pend[SRC_SPEC] <= 1'b1;
            else if (err_rst) pend[SRC_SPEC] <= 1'b0;
            if (tx_fire)      pend[SRC_TX]   <= 1'b1;
            else if (tx_wr)   pend[SRC_TX]   <= 1'b0;
            if (ext_set)      pend[SRC_EXT]  <= 1'b1;
            else if (ext_rst) pend[SRC_EXT]  <= 1'b0;
        end
    end
endmodule

// File: rtl/ivc_arbiter.sv
// Module: fixed-priority picker over the enabled requests, indexed by source
// code. Purely combinational; the order comes from ivc_pkg::rank_to_code.
module ivc_arbiter
    import ivc_pkg::*;
(
    input  logic [NSRC-1:0]   req,
    output logic              hit,
    output logic [CODE_W-1:0] code
);
    // Scan lowest to highest priority so the most urgent request wins last
    always_comb begin
        hit  = 1'b0;
        code = '0;
        for (int r = NSRC - 1; r >= 0; r--) begin
            if (req[rank_to_code(r)]) begin
                hit  = 1'b1;
                code = rank_to_code(r);
            end
        end
    end
endmodule

// File: rtl/ivc_vec_reg.sv
// Module: acknowledge-time vector latch. Merges the winning code into the
// base vector when modification is on and a request wins; otherwise the base
// passes through. Assumes CODE_LSB + CODE_W <= VEC_W.
module ivc_vec_reg
    import ivc_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int CODE_LSB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iack,
    input  logic              hit,
    input  logic [CODE_W-1:0] code,
    input  logic              sav_any,
    input  logic [VEC_W-1:0]  base,
    output logic [VEC_W-1:0]  vec
);
    logic [VEC_W-1:0] merged;

    // Replace the code field of the base with the winning source code
    always_comb begin
        merged = base;
        if (sav_any && hit) merged[CODE_LSB +: CODE_W] = code;
    end

    // Capture the vector only on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)    vec <= '0;
        else if (iack) vec <= merged;
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
// Module: top of the two-channel interrupt vector controller. Holds the
// per-channel control registers and the base vector, builds the enabled
// request set and drives irq and the latched vector.
// Assumes single-cycle event and command strobes from the channels.
module irq_vec_ctrl
    import ivc_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int CODE_LSB = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   rx_char_set,
    input  logic [NCH-1:0]   rx_spec_set,
    input  logic [NCH-1:0]   tx_empty_set,
    input  logic [NCH-1:0]   ext_set,
    input  logic [NCH-1:0]   rx_rd,
    input  logic [NCH-1:0]   tx_wr,
    input  logic [NCH-1:0]   err_rst,
    input  logic [NCH-1:0]   ext_rst,
    input  logic [NCH-1:0]   ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             base_we,
    input  logic [VEC_W-1:0] base_wdata,
    input  logic             iack,
    output logic             irq,
    output logic [VEC_W-1:0] vec,
    output logic [NSRC-1:0]  pend
);
    logic [CTL_W-1:0]  ctl_q [NCH];
    logic [VEC_W-1:0]  base_q;
    logic [NSRC-1:0]   en_by_code;
    logic [NCH-1:0]    sav_bits;
    logic              sav_any;
    logic              hit;
    logic [CODE_W-1:0] code;

    // Base vector register
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_wdata;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int GB = group_of(c) * SRC_PER_CH;

        // Per-channel control register
        always_ff @(posedge clk) begin
            if (!rst_n)        ctl_q[c] <= '0;
            else if (ctl_we[c]) ctl_q[c] <= ctl_wdata;
        end

        assign en_by_code[GB + SRC_TX]   = ctl_q[c][CTL_EN_TX];
        assign en_by_code[GB + SRC_EXT]  = ctl_q[c][CTL_EN_EXT];
        assign en_by_code[GB + SRC_RXC]  = ctl_q[c][CTL_EN_RXC];
        assign en_by_code[GB + SRC_SPEC] = ctl_q[c][CTL_EN_SPEC];
        assign sav_bits[c]               = ctl_q[c][CTL_SAV];

        ivc_src_bank u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .rx_char_set  (rx_char_set[c]),
            .rx_spec_set  (rx_spec_set[c]),
            .tx_empty_set (tx_empty_set[c]),
            .ext_set      (ext_set[c]),
            .rx_rd        (rx_rd[c]),
            .tx_wr        (tx_wr[c]),
            .err_rst      (err_rst[c]),
            .ext_rst      (ext_rst[c]),
            .pend         (pend[GB +: SRC_PER_CH])
        );
    end

    // Modification applies to both channels if either one asks for it
    assign sav_any = |sav_bits;

    ivc_arbiter u_arb (
        .req  (pend & en_by_code),
        .hit  (hit),
        .code (code)
    );

    assign irq = hit;

    ivc_vec_reg #(
        .VEC_W    (VEC_W),
        .CODE_LSB (CODE_LSB)
    ) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .iack    (iack),
        .hit     (hit),
        .code    (code),
        .sav_any (sav_any),
        .base    (base_q),
        .vec     (vec)
    );
endmodule

// File: rtl/ivc_checker.sv
// Module: property checker for irq_vec_ctrl, attached with bind below.
module ivc_checker
    import ivc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iack,
    input logic             irq,
    input logic [VEC_W-1:0] vec,
    input logic [NSRC-1:0]  pend,
    input logic [NCH-1:0]   rx_char_set,
    input logic [NCH-1:0]   rx_rd,
    input logic [NCH-1:0]   ext_set,
    input logic [NCH-1:0]   ext_rst,
    input logic             sav_any,
    input logic [VEC_W-1:0] base_q
);
    // R6: the vector only moves on an acknowledge edge
    p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !iack |=> $stable(vec));

    // R5: with modification off the base is returned as is
    p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !sav_any) |=> (vec == $past(base_q)));

    // R9: an acknowledge with nothing enabled returns the base
    p_noreq_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !irq) |=> (vec == $past(base_q)));

    // R2: a request needs a pending source behind it
    p_irq_has_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        localparam int GB = group_of(c) * SRC_PER_CH;

        // R8: a data read without a new character clears receive pending
        p_rx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_rd[c] && !rx_char_set[c]) |=> !pend[GB + SRC_RXC]);

        // R8: external reset without a new event clears external pending
        p_ext_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_rst[c] && !ext_set[c]) |=> !pend[GB + SRC_EXT]);
    end
endmodule

bind irq_vec_ctrl ivc_checker #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iack        (iack),
    .irq         (irq),
    .vec         (vec),
    .pend        (pend),
    .rx_char_set (rx_char_set),
    .rx_rd       (rx_rd),
    .ext_set     (ext_set),
    .ext_rst     (ext_rst),
    .sav_any     (sav_any),
    .base_q      (base_q)
);

// File: tb/tb_irq_vec_ctrl.sv
// Bench: scoreboard of expected vectors fed by the acknowledge driver and
// drained by a monitor; direct checks on irq and pend.
module tb_irq_vec_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_char_set = '0, rx_spec_set = '0, tx_empty_set = '0, ext_set = '0;
    logic [1:0] rx_rd = '0, tx_wr = '0, err_rst = '0, ext_rst = '0;
    logic [1:0] ctl_we = '0;
    logic [4:0] ctl_wdata = '0;
    logic       base_we = 1'b0;
    logic [7:0] base_wdata = '0;
    logic       iack = 1'b0;
    logic       irq;
    logic [7:0] vec;
    logic [7:0] pend;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q [$];
    string      req_q [$];

    always #2.5 clk = ~clk;

    irq_vec_ctrl #(.VEC_W(8), .CODE_LSB(1)) dut (
        .clk(clk), .rst_n(rst_n),
        .rx_char_set(rx_char_set), .rx_spec_set(rx_spec_set),
        .tx_empty_set(tx_empty_set), .ext_set(ext_set),
        .rx_rd(rx_rd), .tx_wr(tx_wr), .err_rst(err_rst), .ext_rst(ext_rst),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .base_we(base_we), .base_wdata(base_wdata),
        .iack(iack), .irq(irq), .vec(vec), .pend(pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Single-cycle strobe of any mix of events and commands (bit0 = A, bit1 = B)
    task automatic strobe(input logic [1:0] rc, rs, te, ex, rd, tw, er, xr);
        @(negedge clk);
        rx_char_set = rc; rx_spec_set = rs; tx_empty_set = te; ext_set = ex;
        rx_rd = rd; tx_wr = tw; err_rst = er; ext_rst = xr;
        @(negedge clk);
        rx_char_set = '0; rx_spec_set = '0; tx_empty_set = '0; ext_set = '0;
        rx_rd = '0; tx_wr = '0; err_rst = '0; ext_rst = '0;
    endtask

    task automatic wr_ctl(input int ch, input logic [4:0] d);
        @(negedge clk);
        ctl_we[ch] = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = '0;
    endtask

    task automatic wr_base(input logic [7:0] d);
        @(negedge clk);
        base_we = 1'b1; base_wdata = d;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    // Driver: push the expected vector, then acknowledge
    task automatic ack(input string req, input logic [7:0] exp);
        @(negedge clk);
        exp_q.push_back(exp);
        req_q.push_back(req);
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
    endtask

    // Monitor: after each acknowledge edge, compare the latched vector
    initial begin
        forever begin
            @(posedge clk);
            if (iack && rst_n) begin
                @(negedge clk);
                if (exp_q.size() > 0) chk(req_q.pop_front(), 32'(vec), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 irq", 32'(irq), 0);
        chk("R10 vec", 32'(vec), 0);
        chk("R10 pend", 32'(pend), 0);

        wr_base(8'h51);
        // R1: pending latches with all enables off; R2: no request
        strobe(2'b01, 0, 0, 0, 0, 0, 0, 0);
        chk("R1 pend A rxc", 32'(pend), 32'h40);
        chk("R2 irq disabled", 32'(irq), 0);
        wr_ctl(0, 5'b00001);
        chk("R2 irq enabled", 32'(irq), 1);
        ack("R5 passthru", 8'h51);
        // R4: flag set in channel B alone modifies the vector
        wr_ctl(1, 5'b10000);
        ack("R4 sav via B", 8'h5D);
        strobe(0, 0, 0, 0, 2'b01, 0, 0, 0);
        chk("R8 rx read clears", 32'(pend), 0);
        chk("R2 irq after clear", 32'(irq), 0);
        ack("R9 no request", 8'h51);

        // R3: priority across channels and kinds
        wr_ctl(0, 5'b11111);
        wr_ctl(1, 5'b01111);
        strobe(0, 2'b10, 0, 2'b11, 0, 0, 0, 0);
        chk("R1 pend mix", 32'(pend), 32'h2A);
        ack("R3 A ext over B", 8'h5B);
        strobe(0, 0, 0, 0, 0, 0, 0, 2'b01);
        ack("R3 B spec over B ext", 8'h57);
        strobe(0, 0, 0, 0, 0, 0, 2'b10, 0);
        ack("R8 err reset then B ext", 8'h53);

        // R7: transmit empty needs a prior write
        strobe(0, 0, 2'b10, 0, 0, 0, 0, 0);
        chk("R7 unarmed empty", 32'(pend), 32'h02);
        strobe(0, 0, 0, 0, 0, 2'b10, 0, 0);
        strobe(0, 0, 2'b10, 0, 0, 0, 0, 0);
        chk("R7 armed empty", 32'(pend), 32'h03);
        ack("R3 tx over ext", 8'h51);
        strobe(0, 0, 0, 0, 0, 2'b10, 0, 0);
        chk("R7 write clears tx", 32'(pend), 32'h02);
        ack("R3 B ext", 8'h53);

        // R6: vector holds across new requests and base writes
        strobe(0, 2'b01, 0, 0, 0, 0, 0, 0);
        chk("R6 hold after request", 32'(vec), 32'h53);
        wr_base(8'hF0);
        chk("R6 hold after base write", 32'(vec), 32'h53);
        ack("R6 next ack A spec", 8'hFE);
        strobe(2'b01, 0, 0, 0, 0, 0, 0, 0);
        ack("R3 spec over rxc", 8'hFE);
        strobe(0, 0, 0, 0, 0, 0, 2'b01, 0);
        ack("R3 A rxc after err reset", 8'hFC);
        strobe(0, 0, 0, 0, 2'b01, 0, 0, 0);
        chk("R8 rx read", 32'(pend), 32'h02);
        // R8: set wins over a same-cycle clear
        strobe(0, 0, 0, 2'b01, 0, 0, 0, 2'b01);
        chk("R8 set wins", 32'(pend), 32'h22);

        // R2/R1: polling with everything disabled
        wr_ctl(0, 5'b00000);
        wr_ctl(1, 5'b00000);
        chk("R2 all disabled irq", 32'(irq), 0);
        chk("R1 pend kept", 32'(pend), 32'h22);
        ack("R5 base after disable", 8'hF0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule